// File: doc/BRIEF.md
# Bidirectional Cascaded Column Code Loader

This block collects one display line of 6-bit gray-scale codes for a column driver that can be chained with other drivers of the same kind. Each clock it takes a 36-bit word, which holds six codes, and writes the word into the next group of six channels. A line begins with a start pulse. Filling stops by itself, and a strobe edge also ends it. The stored codes stay on a wide parallel output, where a line latch further down the chip can pick them up.

Two start pins are bidirectional. A direction input decides which pin receives the start pulse and which direction the channels fill in. The other pin carries a one-clock hand-off pulse to the next driver in the chain. That pulse comes out in time for the next driver to take the first word that follows the last word of this driver. An inversion input can store every code bit-complemented.

The channel count is set by parameters: `STAGES` groups of `LANES` codes, 50 × 6 = 300 channels by default.

Top module: `colchain_loader`

## Requirements
- R1: While `arst_n` is low, and after it is released, every channel code reads 0 and the cascade pin that is acting as output is low.
- R2: A capturing clock writes lane j of the data word into channel 6·s+j of exactly one stage s. Lane j is `data_i[6j+5:6j]`, with bit 0 as the LSB. Channel c appears on `codes_o[6c+5:6c]`.
- R3: With `dir_up_i` high, the start pulse is taken from `start_r_io`. The k-th word of a line (counting from 0) goes to stage k, which covers channels 6k to 6k+5.
- R4: With `dir_up_i` low, the start pulse is taken from `start_l_io`. The k-th word goes to stage STAGES-1-k. Lane order inside the stage stays the same as in R2.
- R5: The start pulse is sampled on a rising clock edge, and the data word on that same edge is stored as word 0.
- R6: The cascade output goes high right after the edge that stores word STAGES-1, which is the 50th clock of the line counting the start clock. It stays high for exactly one clock.
- R7: The cascade pulse leaves on the pin opposite the input pin (`start_l_io` when `dir_up_i` is high, `start_r_io` when it is low). The pin acting as input is high impedance.
- R8: Capture ends after STAGES+2 clocks counted from the start clock. Words after word STAGES-1, and all words that arrive before the next start pulse, change no channel.
- R9: A rising edge of `strobe_i`, sampled on the clock, ends capture at once. The word on that edge is not stored and no stored code changes. A strobe edge takes priority over a start pulse on the same clock.
- R10: With `invert_i` high, each code is stored bitwise complemented. With it low, each code is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data and control clock, rising edge |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_up_i | input | 1 | Fill direction: 1 fills upward from channel 0, 0 fills downward |
| start_r_io | inout | 1 | Start input when `dir_up_i`=1, cascade output when 0 |
| start_l_io | inout | 1 | Start input when `dir_up_i`=0, cascade output when 1 |
| data_i | input | 36 | Six 6-bit codes, lane 0 in the low bits |
| invert_i | input | 1 | Store codes complemented when high |
| strobe_i | input | 1 | Line strobe; its rising edge ends capture |
| codes_o | output | 1800 | All stored channel codes, channel 0 in the low bits |

## Verification
The assertions assume that the direction input does not change while a line is loading. They also assume that the start pulse lasts one clock and that the input pin is driven only by the driver before this one. The bench changes direction only between lines, while no pulse is in flight. It drives the start pin only on the side chosen as input, and releases that pin before it checks for high impedance. Strobe pulses are placed away from start pulses, except in the priority case that R9 names, and they stay high for two clocks. Because of this, each strobe gives exactly one sampled rising edge.

// File: rtl/colchain_pkg.sv
package colchain_pkg;

  // Fill order selected by the direction input.
  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;

  // Default geometry of one captured word.
  localparam int unsigned CL_CODE_W = 6;
  localparam int unsigned CL_LANES  = 6;
  // Extra clocks the pointer keeps running after the last stage is filled.
  localparam int unsigned CL_TAIL   = 2;

endpackage

// File: rtl/colchain_rst_sync.sv
module colchain_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n_o = hold_q;

endmodule

// File: rtl/colchain_pointer.sv
module colchain_pointer #(
  parameter int unsigned STAGES = 50,
  parameter int unsigned TAIL   = colchain_pkg::CL_TAIL,
  localparam int unsigned SPAN  = STAGES + TAIL,
  localparam int unsigned CW    = $clog2(SPAN + 1),
  localparam int unsigned OW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stb_i,
  output logic          wr_en_o,
  output logic [OW-1:0] wr_ord_o,
  output logic          cascade_o
);

  logic          stb_q;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          casc_q, casc_d;

  logic          stb_rise;
  logic          arm;
  logic [CW-1:0] ord;
  logic          wr_en;

  // Next-state logic
  always_comb begin
    stb_rise = stb_i & ~stb_q;
    arm      = start_i & ~stb_rise;
    ord      = arm ? '0 : cnt_q;
    wr_en    = (arm | busy_q) & ~stb_rise & (ord < CW'(STAGES));

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (stb_rise) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (arm) begin
      busy_d = 1'b1;
      cnt_d  = CW'(1);
    end else if (busy_q) begin
      if (cnt_q == CW'(SPAN - 1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end

    casc_d = wr_en & (ord == CW'(STAGES - 1));
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      casc_q <= 1'b0;
    end else begin
      stb_q  <= stb_i;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      casc_q <= casc_d;
    end
  end

  assign wr_en_o   = wr_en;
  assign wr_ord_o  = ord[OW-1:0];
  assign cascade_o = casc_q;

  // R6: the hand-off pulse never lasts longer than one clock
  assert_cascade_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    casc_q |=> !casc_q);

  // R8: the clock count stays within the capture window, and is zero when idle
  assert_count_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(SPAN - 1)) && (busy_q || cnt_q == '0));

  // R9: a strobe edge leaves the loader idle on the next clock
  assert_strobe_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !stb_q) |=> (!busy_q && !casc_q));

  // R5: a start pulse arms the loader with word 0 already taken
  assert_start_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !(stb_i && !stb_q)) |=> (busy_q && cnt_q == CW'(1)));

endmodule

// File: rtl/colchain_stage_bank.sv
module colchain_stage_bank #(
  parameter int unsigned STAGES = 50,
  parameter int unsigned LANES  = colchain_pkg::CL_LANES,
  parameter int unsigned CODE_W = colchain_pkg::CL_CODE_W,
  localparam int unsigned WORD_W = LANES * CODE_W,
  localparam int unsigned OW     = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dir_up_i,
  input  logic                     wr_en_i,
  input  logic [OW-1:0]            wr_ord_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [STAGES*WORD_W-1:0] codes_o
);

  logic [STAGES-1:0]             sel;
  logic [STAGES-1:0][WORD_W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned FWD = s;
    localparam int unsigned REV = STAGES - 1 - s;

    always_comb begin
      sel[s] = wr_en_i &
               (dir_up_i ? (wr_ord_i == OW'(FWD)) : (wr_ord_i == OW'(REV)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (sel[s]) begin
        stage_q[s] <= word_i;
      end
    end
  end

  assign codes_o = stage_q;

  // R2: each capturing clock targets at most one stage
  assert_one_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R8: without a write request, no stored code moves
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(codes_o));

endmodule

// File: rtl/colchain_loader.sv
module colchain_loader #(
  parameter int unsigned STAGES = 50,
  parameter int unsigned LANES  = colchain_pkg::CL_LANES,
  parameter int unsigned CODE_W = colchain_pkg::CL_CODE_W,
  localparam int unsigned WORD_W = LANES * CODE_W,
  localparam int unsigned OW     = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                     clk,
  input  logic                     arst_n,
  input  logic                     dir_up_i,
  inout  wire                      start_r_io,
  inout  wire                      start_l_io,
  input  logic [WORD_W-1:0]        data_i,
  input  logic                     invert_i,
  input  logic                     strobe_i,
  output logic [STAGES*WORD_W-1:0] codes_o
);

  import colchain_pkg::*;

  logic              rst_n;
  fill_dir_e         dir;
  logic              start_in;
  logic              cascade;
  logic              wr_en;
  logic [OW-1:0]     wr_ord;
  logic [WORD_W-1:0] word_in;

  colchain_rst_sync u_rst (
    .clk      (clk),
    .arst_n   (arst_n),
    .srst_n_o (rst_n)
  );

  assign dir = fill_dir_e'(dir_up_i);

  // Pin roles: the input-side pin is released, the far pin carries the hand-off.
  assign start_in   = (dir == FILL_UP) ? start_r_io : start_l_io;
  assign start_r_io = (dir == FILL_UP) ? 1'bz : cascade;
  assign start_l_io = (dir == FILL_UP) ? cascade : 1'bz;

  // Optional complement on entry, lane by lane
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign word_in[j*CODE_W +: CODE_W] = data_i[j*CODE_W +: CODE_W] ^ {CODE_W{invert_i}};
  end

  colchain_pointer #(
    .STAGES (STAGES),
    .TAIL   (CL_TAIL)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_in),
    .stb_i     (strobe_i),
    .wr_en_o   (wr_en),
    .wr_ord_o  (wr_ord),
    .cascade_o (cascade)
  );

  colchain_stage_bank #(
    .STAGES (STAGES),
    .LANES  (LANES),
    .CODE_W (CODE_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_up_i (dir_up_i),
    .wr_en_i  (wr_en),
    .wr_ord_i (wr_ord),
    .word_i   (word_in),
    .codes_o  (codes_o)
  );

  // R1: while reset is held, the bank reads all zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (codes_o == '0) || !rst_n);

endmodule

// File: tb/colchain_loader_tb_top.sv
module colchain_loader_tb_top;

  localparam int ST = 50;
  localparam int NCH = ST * 6;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          dir_up;
  logic [35:0]   data;
  logic          invert;
  logic          strobe;
  logic [NCH*6-1:0] codes;

  logic drv_r_en, drv_r_val, drv_l_en, drv_l_val;
  wire  start_r, start_l;

  assign start_r = drv_r_en ? drv_r_val : 1'bz;
  assign start_l = drv_l_en ? drv_l_val : 1'bz;

  int checks = 0;
  int errors = 0;
  logic [5:0] expc [NCH];

  always #10 clk = ~clk;

  colchain_loader dut_i (
    .clk        (clk),
    .arst_n     (arst_n),
    .dir_up_i   (dir_up),
    .start_r_io (start_r),
    .start_l_io (start_l),
    .data_i     (data),
    .invert_i   (invert),
    .strobe_i   (strobe),
    .codes_o    (codes)
  );

  function automatic logic [5:0] gen_code(int k, int j, int seed);
    return 6'((k * 7 + j * 11 + seed) & 63);
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (codes[c*6 +: 6] !== expc[c]) begin
        errors++;
        $display("FAIL %s channel %0d actual %h expected %h", req, c, codes[c*6 +: 6], expc[c]);
      end
    end
  endtask

  // One line: start on word 0, total words, optional strobe at word stb_at.
  task automatic run_line(string req, logic up, logic inv, int seed, int total, int stb_at);
    logic casc;
    bit   stopped;
    @(negedge clk);
    dir_up = up;
    invert = inv;
    drv_r_en = up;  drv_r_val = 1'b0;
    drv_l_en = !up; drv_l_val = 1'b0;
    stopped = 1'b0;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      for (int j = 0; j < 6; j++) data[j*6 +: 6] = gen_code(k, j, seed);
      if (up) drv_r_val = (k == 0); else drv_l_val = (k == 0);
      strobe = (stb_at >= 0) && (k >= stb_at) && (k < stb_at + 2);
      if (stb_at >= 0 && k >= stb_at) stopped = 1'b1;
      if (k < ST && !stopped) begin
        for (int j = 0; j < 6; j++) begin
          int stg;
          stg = up ? k : (ST - 1 - k);
          expc[stg*6 + j] = inv ? ~gen_code(k, j, seed) : gen_code(k, j, seed);
        end
      end
      @(posedge clk);
      #2;
      casc = up ? start_l : start_r;
      // R6 / R7: hand-off pulse only right after the edge storing word 49
      check_bit({req, " R6 cascade"}, casc, (k == ST - 1) && !stopped);
    end
    @(negedge clk);
    strobe = 1'b0;
    drv_r_val = 1'b0;
    drv_l_val = 1'b0;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic t_reset();
    arst_n = 1'b0;
    dir_up = 1'b1; invert = 1'b0; strobe = 1'b0; data = '0;
    drv_r_en = 1'b1; drv_r_val = 1'b0; drv_l_en = 1'b0; drv_l_val = 1'b0;
    for (int c = 0; c < NCH; c++) expc[c] = '0;
    repeat (3) @(posedge clk);
    #2;
    check_all("R1 during reset");
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");
    check_bit("R1 cascade low", start_l, 1'b0);
  endtask

  task automatic t_fill_up();
    run_line("R2 R3 R5 fill up", 1'b1, 1'b0, 3, 56, -1);
  endtask

  task automatic t_fill_down();
    run_line("R4 fill down", 1'b0, 1'b0, 20, 56, -1);
  endtask

  task automatic t_invert();
    run_line("R10 inverted", 1'b1, 1'b1, 41, 56, -1);
  endtask

  task automatic t_strobe();
    run_line("R9 strobe stop", 1'b0, 1'b0, 9, 20, 10);
  endtask

  task automatic t_strobe_vs_start();
    // R9: strobe edge on the start clock wins, nothing is stored
    run_line("R9 strobe beats start", 1'b1, 1'b0, 30, 12, 0);
  endtask

  task automatic t_autostop();
    // R8: words with no new start after the window change nothing
    @(negedge clk);
    dir_up = 1'b1; drv_r_en = 1'b1; drv_r_val = 1'b0; drv_l_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      data = {6{6'(k + 5)}};
    end
    @(negedge clk);
    check_all("R8 no capture while idle");
  endtask

  task automatic t_hiz();
    @(negedge clk);
    dir_up = 1'b1; drv_r_en = 1'b0; drv_l_en = 1'b0;
    #2;
    check_bit("R7 input pin released up", start_r, 1'bz);
    check_bit("R7 output pin driven up", start_l, 1'b0);
    @(negedge clk);
    dir_up = 1'b0;
    #2;
    check_bit("R7 input pin released down", start_l, 1'bz);
    check_bit("R7 output pin driven down", start_r, 1'b0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    arst_n = 1'b0;
    for (int c = 0; c < NCH; c++) expc[c] = '0;
    @(negedge clk);
    check_all("R1 reset clears stored line");
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_up();
    t_fill_down();
    t_invert();
    t_strobe();
    t_strobe_vs_start();
    t_autostop();
    t_hiz();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule